// File: doc/BRIEF.md
# Debug Trigger and Trace Capture Controller

This block sequences two comparator match strobes, A and B, into a trigger event. It uses that trigger to decide when a small trace buffer starts or stops collecting entries. The comparators sit outside the block and feed it one-cycle match pulses. The block emits one write per stored item, as a write-enable strobe with write data, to an 8-entry circular trace buffer outside it.

Software picks one of five trigger modes and a begin/end qualifier, then pulses the arm input. Mode and qualifier are captured on that pulse.

Each mode sets the sticky status flags for the matches it honours:
- In begin-type capture, storing starts at the trigger and ends once the buffer has taken eight entries.
- In end-type capture, storing runs from arming onward, overwriting the oldest entry, and freezes at the trigger.
- In either case the end of capture raises the completion flag and drops the armed indication.

What is stored depends on the mode:
- Most modes store change-of-flow addresses.
- The two event-only modes store the data-bus value seen at each qualifying B match instead. These modes always use begin-type capture.

Top module: `dbg_trace_ctl`

## Requirements
- R1: After reset, armed, AF, BF, CF and the write strobe are all 0.
- R2: A cycle with arm high sets armed and clears AF, BF and CF one cycle later. It also captures the mode code and the begin bit (1 = begin-type, 0 = end-type).
- R3: Mode code 0 (A only): an A match sets AF, and B matches never set BF. Flags stay set until the next arm.
- R4: Mode code 1 (A or B): an A match sets AF and a B match sets BF. A and B in the same cycle set both flags.
- R5: Mode code 2 (A then B): a B match does not set BF until an A match has been seen since arming. An A and B match in the same cycle counts only as A.
- R6: Mode code 3 (event only B): a B match sets BF and is the trigger. Each B match writes the data-bus value, zero-extended in the low bits of the write data. Change-of-flow inputs are not stored. Capture is begin-type whatever the begin bit.
- R7: Mode code 4 (A then event only B): B matches are ignored until A has been seen. After that, each B match sets BF and writes the zero-extended data-bus value. Capture is begin-type whatever the begin bit.
- R8: In mode codes 0, 1 and 2, each stored entry is the change-of-flow address from a cycle with the change-of-flow valid input high.
- R9: Begin-type capture writes nothing before the trigger and stores from the trigger cycle on. The write that brings the count to 8 sets CF and clears armed.
- R10: End-type capture stores every valid change-of-flow address from arming on, without stopping at 8 entries. The trigger cycle's entry is still written; then CF is set and armed clears.
- R11: Mode codes 5 to 7 are reserved. They set no flag, write nothing and never end the capture.
- R12: Flags, armed, CF, the write strobe and the write data all reflect the inputs of the previous clock cycle.
- R13: While not armed, matches and change-of-flow inputs set no flag and cause no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Arm pulse; captures mode and begin bit |
| mode_i | input | 3 | Trigger mode code (0..4, 5..7 reserved) |
| begin_i | input | 1 | 1 = begin-type capture, 0 = end-type |
| match_a_i | input | 1 | Comparator A match strobe |
| match_b_i | input | 1 | Comparator B match strobe |
| cof_valid_i | input | 1 | Change-of-flow address valid |
| cof_addr_i | input | ADDR_W | Change-of-flow address |
| bus_data_i | input | DATA_W | Data-bus value |
| af_o | output | 1 | Sticky A-match flag |
| bf_o | output | 1 | Sticky B-match flag |
| cf_o | output | 1 | Capture-complete flag |
| armed_o | output | 1 | Capture is armed |
| trc_we_o | output | 1 | Trace buffer write enable |
| trc_wdata_o | output | ADDR_W | Trace buffer write data |

## Verification
Every result of this block is due exactly one clock after the input cycle that causes it. This covers flag changes, armed and CF, and the write strobe with its data. The bench drives each input cycle just after a falling edge and samples at the next falling edge, exactly one rising edge later. Expected writes are queued when the causing cycle is driven, and a monitor pops them at the falling edge after the write appears. A write that comes early, late or unasked is therefore reported as a mismatch, and a queue that still holds entries one idle cycle after a scenario is reported too.

// File: rtl/dbg_trace_pkg.sv
package dbg_trace_pkg;

    typedef enum logic [2:0] {
        TM_A_ONLY       = 3'd0,
        TM_A_OR_B       = 3'd1,
        TM_A_THEN_B     = 3'd2,
        TM_EVT_B        = 3'd3,
        TM_A_THEN_EVT_B = 3'd4
    } trig_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       begin_type;
    } cap_cfg_t;

    typedef struct packed {
        logic a_hit;
        logic b_hit;
        logic trig;
    } trig_evt_t;

    function automatic logic mode_known(input logic [2:0] m);
        return m <= 3'(TM_A_THEN_EVT_B);
    endfunction

    function automatic logic mode_uses_a(input logic [2:0] m);
        return (m == 3'(TM_A_ONLY)) || (m == 3'(TM_A_OR_B)) ||
               (m == 3'(TM_A_THEN_B)) || (m == 3'(TM_A_THEN_EVT_B));
    endfunction

    function automatic logic mode_is_seq(input logic [2:0] m);
        return (m == 3'(TM_A_THEN_B)) || (m == 3'(TM_A_THEN_EVT_B));
    endfunction

    function automatic logic mode_is_event(input logic [2:0] m);
        return (m == 3'(TM_EVT_B)) || (m == 3'(TM_A_THEN_EVT_B));
    endfunction

endpackage

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm_i,
    input  logic       armed_i,
    input  logic [2:0] mode_i,
    input  logic       match_a_i,
    input  logic       match_b_i,
    output logic       af_o,
    output logic       bf_o,
    output trig_evt_t  evt_o
);

    logic a_seen_q;
    logic live;
    logic a_hit;
    logic b_en;
    logic b_hit;
    logic trig;

    // evaluation only in armed cycles that are not themselves arm cycles
    assign live  = armed_i && !arm_i;
    assign a_hit = live && match_a_i && mode_uses_a(mode_i);

    always_comb begin
        case (mode_i)
            3'(TM_A_OR_B),
            3'(TM_EVT_B):        b_en = 1'b1;
            3'(TM_A_THEN_B),
            3'(TM_A_THEN_EVT_B): b_en = a_seen_q;   // same-cycle A does not open B
            default:             b_en = 1'b0;
        endcase
    end

    assign b_hit = live && match_b_i && b_en;

    always_comb begin
        case (mode_i)
            3'(TM_A_ONLY):       trig = a_hit;
            3'(TM_A_OR_B):       trig = a_hit || b_hit;
            3'(TM_A_THEN_B),
            3'(TM_EVT_B),
            3'(TM_A_THEN_EVT_B): trig = b_hit;
            default:             trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_seen_q <= 1'b0;
            af_o     <= 1'b0;
            bf_o     <= 1'b0;
        end else if (arm_i) begin
            a_seen_q <= 1'b0;
            af_o     <= 1'b0;
            bf_o     <= 1'b0;
        end else begin
            if (a_hit && mode_is_seq(mode_i)) a_seen_q <= 1'b1;
            if (a_hit) af_o <= 1'b1;
            if (b_hit) bf_o <= 1'b1;
        end
    end

    assign evt_o = '{a_hit: a_hit, b_hit: b_hit, trig: trig};

endmodule

// File: rtl/dbg_store_qual.sv
module dbg_store_qual
    import dbg_trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      arm_i,
    input  logic      begin_i,
    input  logic      event_i,
    input  logic      known_i,
    input  trig_evt_t evt_i,
    input  logic      cof_valid_i,
    output logic      armed_o,
    output logic      cf_o,
    output logic      store_o
);

    logic             storing_q;
    logic [CNT_W-1:0] fill_q;
    logic             live;
    logic             item_valid;
    logic             window;
    logic             full_hit;
    logic             done;

    assign live       = armed_o && !arm_i && known_i;
    assign item_valid = event_i ? evt_i.b_hit : cof_valid_i;

    // begin-type: open from the trigger cycle; end-type: open from arming
    assign window  = begin_i ? (storing_q || evt_i.trig) : 1'b1;
    assign store_o = live && window && item_valid;

    assign full_hit = begin_i && store_o && (fill_q == CNT_W'(DEPTH - 1));
    assign done     = full_hit || (!begin_i && live && evt_i.trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_o   <= 1'b0;
            cf_o      <= 1'b0;
            storing_q <= 1'b0;
            fill_q    <= '0;
        end else if (arm_i) begin
            armed_o   <= 1'b1;
            cf_o      <= 1'b0;
            storing_q <= 1'b0;
            fill_q    <= '0;
        end else begin
            if (live && evt_i.trig) storing_q <= 1'b1;
            if (begin_i && store_o) fill_q <= fill_q + CNT_W'(1);
            if (done) begin
                armed_o <= 1'b0;
                cf_o    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbg_trace_wr.sv
module dbg_trace_wr #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int WD_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store_i,
    input  logic              event_i,
    input  logic [ADDR_W-1:0] cof_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              we_o,
    output logic [WD_W-1:0]   wdata_o
);

    logic [WD_W-1:0] item;

    assign item = event_i ? WD_W'(bus_data_i) : WD_W'(cof_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            we_o    <= 1'b0;
            wdata_o <= '0;
        end else begin
            we_o <= store_i;
            if (store_i) wdata_o <= item;
        end
    end

endmodule

// File: rtl/dbg_trace_ctl.sv
module dbg_trace_ctl
    import dbg_trace_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int WD_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [2:0]        mode_i,
    input  logic              begin_i,
    input  logic              match_a_i,
    input  logic              match_b_i,
    input  logic              cof_valid_i,
    input  logic [ADDR_W-1:0] cof_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic              af_o,
    output logic              bf_o,
    output logic              cf_o,
    output logic              armed_o,
    output logic              trc_we_o,
    output logic [WD_W-1:0]   trc_wdata_o
);

    cap_cfg_t  cfg_q;
    trig_evt_t evt;
    logic      evt_mode;
    logic      eff_begin;
    logic      known;
    logic      store;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '{mode: 3'(TM_A_ONLY), begin_type: 1'b1};
        else if (arm_i) cfg_q <= '{mode: mode_i, begin_type: begin_i};
    end

    assign evt_mode  = mode_is_event(cfg_q.mode);
    assign eff_begin = cfg_q.begin_type || evt_mode;   // event modes force begin-type
    assign known     = mode_known(cfg_q.mode);

    dbg_trig_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm_i),
        .armed_i   (armed_o),
        .mode_i    (cfg_q.mode),
        .match_a_i (match_a_i),
        .match_b_i (match_b_i),
        .af_o      (af_o),
        .bf_o      (bf_o),
        .evt_o     (evt)
    );

    dbg_store_qual #(.DEPTH(DEPTH)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .begin_i     (eff_begin),
        .event_i     (evt_mode),
        .known_i     (known),
        .evt_i       (evt),
        .cof_valid_i (cof_valid_i),
        .armed_o     (armed_o),
        .cf_o        (cf_o),
        .store_o     (store)
    );

    dbg_trace_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .store_i    (store),
        .event_i    (evt_mode),
        .cof_addr_i (cof_addr_i),
        .bus_data_i (bus_data_i),
        .we_o       (trc_we_o),
        .wdata_o    (trc_wdata_o)
    );

endmodule

// File: rtl/dbg_trace_ctl_chk.sv
module dbg_trace_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm_i,
    input logic [2:0] mode_q,
    input logic       af_o,
    input logic       bf_o,
    input logic       cf_o,
    input logic       armed_o,
    input logic       trc_we_o
);

    AST_ARM_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_o && !af_o && !bf_o && !cf_o)); // R2

    AST_AF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (af_o && !arm_i) |=> af_o); // R3

    AST_BF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (bf_o && !arm_i) |=> bf_o); // R4

    AST_SEQ_B_AFTER_A: assert property (@(posedge clk) disable iff (rst)
        ($rose(bf_o) && (mode_q == 3'd2 || mode_q == 3'd4)) |-> af_o); // R5

    AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        $rose(cf_o) |-> !armed_o); // R9

    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (armed_o && mode_q > 3'd4) |=> !trc_we_o); // R11

    AST_WRITE_NEEDS_ARMED: assert property (@(posedge clk) disable iff (rst)
        trc_we_o |-> $past(armed_o)); // R13

endmodule

bind dbg_trace_ctl dbg_trace_ctl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_i),
    .mode_q   (cfg_q.mode),
    .af_o     (af_o),
    .bf_o     (bf_o),
    .cf_o     (cf_o),
    .armed_o  (armed_o),
    .trc_we_o (trc_we_o)
);

// File: tb/dbg_trace_ctl_bench.sv
module dbg_trace_ctl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        arm_i;
    logic [2:0]  mode_i;
    logic        begin_i;
    logic        match_a_i;
    logic        match_b_i;
    logic        cof_valid_i;
    logic [15:0] cof_addr_i;
    logic [7:0]  bus_data_i;
    logic        af_o, bf_o, cf_o, armed_o, trc_we_o;
    logic [15:0] trc_wdata_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    dbg_trace_ctl u_dbg_trace_ctl (
        .clk(clk), .rst(rst), .arm_i(arm_i), .mode_i(mode_i), .begin_i(begin_i),
        .match_a_i(match_a_i), .match_b_i(match_b_i), .cof_valid_i(cof_valid_i),
        .cof_addr_i(cof_addr_i), .bus_data_i(bus_data_i), .af_o(af_o), .bf_o(bf_o),
        .cf_o(cf_o), .armed_o(armed_o), .trc_we_o(trc_we_o), .trc_wdata_o(trc_wdata_o)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: writes are due one cycle after the driving cycle (R12)
    always @(negedge clk) begin
        if (!rst && trc_we_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R12 unexpected write: actual %h expected none", trc_wdata_o);
            end else begin
                chk(req_q.pop_front(), "write data", trc_wdata_o, exp_q.pop_front());
            end
        end
    end

    // one input cycle; returns at the falling edge where its results are visible
    task automatic step(input logic a, input logic b, input logic cv, input logic [15:0] ca,
                        input logic [7:0] d, input logic expw, input logic [15:0] expd,
                        input string req);
        match_a_i = a; match_b_i = b; cof_valid_i = cv; cof_addr_i = ca; bus_data_i = d;
        if (expw) begin
            exp_q.push_back(expd);
            req_q.push_back(req);
        end
        @(negedge clk);
        match_a_i = 1'b0; match_b_i = 1'b0; cof_valid_i = 1'b0;
    endtask

    task automatic arm(input logic [2:0] m, input logic b);
        arm_i = 1'b1; mode_i = m; begin_i = b;
        @(negedge clk);
        arm_i = 1'b0;
        chk("R2", "armed after arm", 16'(armed_o), 16'd1);
        chk("R2", "flags after arm", {13'd0, af_o, bf_o, cf_o}, 16'd0);
    endtask

    task automatic drain(input string req);
        step(0, 0, 0, 16'h0, 8'h0, 0, 16'h0, req);
        chk(req, "pending writes", 16'(exp_q.size()), 16'd0);
        exp_q.delete(); req_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; arm_i = 0; mode_i = 0; begin_i = 0; match_a_i = 0; match_b_i = 0;
        cof_valid_i = 0; cof_addr_i = 0; bus_data_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "reset outputs", {11'd0, armed_o, af_o, bf_o, cf_o, trc_we_o}, 16'd0);

        // R13: disarmed inputs have no effect
        step(1, 1, 1, 16'hDEAD, 8'h12, 0, 16'h0, "R13");
        chk("R13", "flags while disarmed", {13'd0, af_o, bf_o, cf_o}, 16'd0);
        drain("R13");

        // R3 / R9 / R8: A only, begin-type
        arm(3'd0, 1'b1);
        step(0, 1, 0, 16'h0, 8'h0, 0, 16'h0, "R3");
        chk("R3", "BF in A-only", 16'(bf_o), 16'd0);
        step(0, 0, 1, 16'h0F00, 8'h0, 0, 16'h0, "R9");
        step(1, 0, 1, 16'h1000, 8'h0, 1, 16'h1000, "R9");
        chk("R3", "AF on A", 16'(af_o), 16'd1);
        for (int i = 1; i < 8; i++) begin
            step(0, 0, 1, 16'h1000 + 16'(i), 8'h0, 1, 16'h1000 + 16'(i), "R8");
            if (i == 6) chk("R9", "armed before full", 16'(armed_o), 16'd1);
        end
        chk("R9", "CF and armed at full", {14'd0, cf_o, armed_o}, 16'b10);
        step(1, 0, 1, 16'h1FFF, 8'h0, 0, 16'h0, "R13");
        drain("R9");

        // R4 / R10: A or B, end-type
        arm(3'd1, 1'b0);
        for (int i = 0; i < 10; i++)
            step(0, 0, 1, 16'h2000 + 16'(i), 8'h0, 1, 16'h2000 + 16'(i), "R10");
        chk("R10", "still armed past depth", 16'(armed_o), 16'd1);
        step(1, 1, 1, 16'h2222, 8'h0, 1, 16'h2222, "R10");
        chk("R4", "both flags same cycle", {14'd0, af_o, bf_o}, 16'b11);
        chk("R10", "CF and armed at trigger", {14'd0, cf_o, armed_o}, 16'b10);
        step(0, 0, 1, 16'h2300, 8'h0, 0, 16'h0, "R10");
        drain("R10");

        arm(3'd1, 1'b1);
        step(0, 1, 0, 16'h0, 8'h0, 0, 16'h0, "R4");
        chk("R4", "B alone", {14'd0, af_o, bf_o}, 16'b01);
        drain("R4");

        // R5 / R8: A then B, begin-type
        arm(3'd2, 1'b1);
        step(0, 1, 1, 16'h3000, 8'h0, 0, 16'h0, "R5");
        chk("R5", "B before A", {14'd0, af_o, bf_o}, 16'b00);
        step(1, 1, 1, 16'h3001, 8'h0, 0, 16'h0, "R5");
        chk("R5", "A and B same cycle", {14'd0, af_o, bf_o}, 16'b10);
        step(0, 1, 1, 16'h3002, 8'h77, 1, 16'h3002, "R8");
        chk("R5", "B after A", 16'(bf_o), 16'd1);
        step(0, 0, 1, 16'h3003, 8'h55, 1, 16'h3003, "R8");
        drain("R8");

        // R6: event only B, begin bit 0 ignored
        arm(3'd3, 1'b0);
        step(0, 0, 1, 16'h4000, 8'h0, 0, 16'h0, "R6");
        step(0, 1, 1, 16'h4001, 8'hA5, 1, 16'h00A5, "R6");
        chk("R6", "BF on B", 16'(bf_o), 16'd1);
        step(0, 0, 1, 16'h4002, 8'h99, 0, 16'h0, "R6");
        chk("R6", "armed after trigger", 16'(armed_o), 16'd1);
        for (int i = 0; i < 7; i++)
            step(0, 1, 0, 16'h0, 8'h10 + 8'(i), 1, 16'h0010 + 16'(i), "R6");
        chk("R6", "CF and armed at full", {14'd0, cf_o, armed_o}, 16'b10);
        drain("R6");

        // R7: A then event only B, begin bit 0 ignored
        arm(3'd4, 1'b0);
        step(0, 1, 0, 16'h0, 8'h11, 0, 16'h0, "R7");
        chk("R7", "B before A", 16'(bf_o), 16'd0);
        step(1, 0, 0, 16'h0, 8'h22, 0, 16'h0, "R7");
        step(0, 1, 1, 16'h5000, 8'h3C, 1, 16'h003C, "R7");
        chk("R7", "flags after B", {14'd0, af_o, bf_o}, 16'b11);
        chk("R7", "armed after trigger", 16'(armed_o), 16'd1);
        step(0, 1, 0, 16'h0, 8'h3D, 1, 16'h003D, "R7");
        drain("R7");

        // R11: reserved codes
        arm(3'd5, 1'b1);
        step(1, 1, 1, 16'h6000, 8'h01, 0, 16'h0, "R11");
        chk("R11", "code 5 flags/armed", {12'd0, af_o, bf_o, cf_o, armed_o}, 16'b0001);
        arm(3'd7, 1'b0);
        step(1, 1, 1, 16'h6001, 8'h02, 0, 16'h0, "R11");
        chk("R11", "code 7 flags/armed", {12'd0, af_o, bf_o, cf_o, armed_o}, 16'b0001);
        drain("R11");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule